// File: doc/BRIEF.md
# Routed Interrupt Controller with Pending Clear

This block collects thirty-two interrupt request inputs and delivers each one to a chosen processor interrupt line. Every source has a 4-bit configuration field. It holds an enable flag and a 3-bit line selector. Eight of these fields are packed into each 32-bit control word, so software can send any source to any of the processor lines. A word-addressed register port gives read and write access to the control words. The same port also carries a write-one-to-clear mask for pending state and a read-only view of the raw pending bits.

A parameter marks each source as edge-type or level-type. An edge-type source latches a sticky pending bit on a rising input and keeps it until software clears it. A level-type source shows pending for as long as its device drives it high, whatever software writes to the clear mask. Pending bits are gated by their enables and ORed onto the selected lines. Each line is registered, so it responds one clock after its inputs change. Priority, vectoring and the interrupting devices are outside this block.

Top module: `irq_router`

## Requirements
- R1: Synchronous active-high reset zeroes every configuration field, meaning disabled with selector 0, and also every pending bit and every output line.
- R2: Word address k (byte address 4*k, k = 0..3) holds the fields of sources 8k to 8k+7. Source n uses bits [(n%8)*4+3 : (n%8)*4] of word n/8. A write stores the whole word, and a read returns the stored value.
- R3: Selector bits [2:0] of a field name the output line, 0 to 6. Line 5 is never driven, and selector values 5 and 7 reach no line.
- R4: Field bit 3 is the enable. With it at 0, the source reaches no output line whatever its pending state.
- R5: An edge-type source sets its pending bit one clock after a 0-to-1 change at its input. The bit stays set after the input falls.
- R6: A write to byte address 0x10 clears the pending bit of every edge-type source whose data bit is 1. Data bits at 0 leave the pending bits unchanged.
- R7: When a rising edge and a clear of the same edge-type source fall in the same cycle, the edge wins and the bit stays set.
- R8: A level-type source's pending bit follows its input, one clock late. A clear write has no effect on it.
- R9: A read of byte address 0x14 returns the 32 pending bits, bit n for source n, whatever the enables are.
- R10: Output line L is registered. It becomes 1 one clock after some source is pending, enabled and has selector L. It responds with the same one-clock lag to changes in pending state, enable and selector.
- R11: Writes to 0x14 and to unmapped addresses (0x18, 0x1C) change nothing. Reads of 0x10, 0x18 and 0x1C return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Byte address of the register access; bits [1:0] are ignored |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | 32 | Interrupt request inputs, one per source |
| irq_line | output | 7 | Registered processor interrupt lines |

## Verification
The bench builds the block with 32 sources and 7 output lines. It marks sources 24 to 31 as level-type and the rest as edge-type, so both pending behaviours can be tested through the same clear register. With seven lines, the unused line 5 and selector value 7 are reachable, and a random phase writes arbitrary control words to exercise both. Directed steps cover the same-cycle edge-versus-clear case, the clear attempt on a held level source and the registered one-clock lag.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;

    localparam int unsigned DATA_W          = 32;
    localparam int unsigned SEL_W           = 3;
    localparam int unsigned FIELD_W         = SEL_W + 1;
    localparam int unsigned FIELDS_PER_WORD = DATA_W / FIELD_W;
    localparam int unsigned UNUSED_LINE     = 5;

    typedef struct packed {
        logic             enable;
        logic [SEL_W-1:0] sel;
    } src_cfg_t;

    typedef enum logic [1:0] {
        ACC_CTRL,
        ACC_CLEAR,
        ACC_STATUS,
        ACC_NONE
    } acc_kind_t;

    function automatic logic sel_routes(logic [SEL_W-1:0] sel, int unsigned line);
        return (sel == SEL_W'(line)) && (line != UNUSED_LINE);
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 32,
    parameter int unsigned WORD_IDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [WORD_IDX_W-1:0]   wr_word,
    input  logic [DATA_W-1:0]       wr_data,
    output src_cfg_t [NUM_SRC-1:0]  cfg
);
    localparam int unsigned NUM_WORDS = NUM_SRC / FIELDS_PER_WORD;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            for (int unsigned w = 0; w < NUM_WORDS; w++) begin
                if (wr_word == WORD_IDX_W'(w)) begin
                    cfg[w*FIELDS_PER_WORD +: FIELDS_PER_WORD] <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/irq_pending.sv
`timescale 1ns/1ps
module irq_pending #(
    parameter int unsigned         NUM_SRC   = 32,
    parameter logic [NUM_SRC-1:0]  LEVEL_SRC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic bit_q;
        assign pend[i] = bit_q;

        if (LEVEL_SRC[i]) begin : g_level
            // A level source mirrors its input; clearing cannot drop it.
            logic unused_clr;
            assign unused_clr = clr_mask[i];
            always_ff @(posedge clk) begin
                if (rst) bit_q <= 1'b0;
                else     bit_q <= src_in[i];
            end
        end else begin : g_edge
            logic seen_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    seen_q <= 1'b0;
                    bit_q  <= 1'b0;
                end else begin
                    seen_q <= src_in[i];
                    // A fresh edge outranks a clear in the same cycle.
                    bit_q  <= (src_in[i] & ~seen_q) | (bit_q & ~clr_mask[i]);
                end
            end
        end
    end
endmodule

// File: rtl/irq_route.sv
`timescale 1ns/1ps
module irq_route
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned NUM_LINES = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_SRC-1:0]      pend,
    input  src_cfg_t [NUM_SRC-1:0]  cfg,
    output logic [NUM_LINES-1:0]    line_q
);
    logic [NUM_LINES-1:0] line_d;

    always_comb begin
        line_d = '0;
        for (int unsigned l = 0; l < NUM_LINES; l++) begin
            for (int unsigned s = 0; s < NUM_SRC; s++) begin
                if (pend[s] && cfg[s].enable && sel_routes(cfg[s].sel, l)) begin
                    line_d[l] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
    import irq_router_pkg::*;
#(
    parameter int unsigned         NUM_SRC   = 32,
    parameter int unsigned         NUM_LINES = 7,
    parameter int unsigned         ADDR_W    = 5,
    parameter logic [NUM_SRC-1:0]  LEVEL_SRC = 32'hFF00_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   src_in,
    output logic [NUM_LINES-1:0] irq_line
);
    localparam int unsigned NUM_WORDS = NUM_SRC / FIELDS_PER_WORD;
    localparam int unsigned WORD_W    = ADDR_W - 2;
    localparam int unsigned CLR_WORD  = NUM_WORDS;
    localparam int unsigned STAT_WORD = NUM_WORDS + 1;

    logic [WORD_W-1:0]      word;
    logic [1:0]             unused_byte_sel;
    acc_kind_t              kind;
    logic [NUM_SRC-1:0]     clr_mask;
    logic [NUM_SRC-1:0]     pend_q;
    src_cfg_t [NUM_SRC-1:0] cfg_q;

    assign word            = bus_addr[ADDR_W-1:2];
    assign unused_byte_sel = bus_addr[1:0];

    always_comb begin
        if (word < WORD_W'(NUM_WORDS))       kind = ACC_CTRL;
        else if (word == WORD_W'(CLR_WORD))  kind = ACC_CLEAR;
        else if (word == WORD_W'(STAT_WORD)) kind = ACC_STATUS;
        else                                 kind = ACC_NONE;
    end

    assign clr_mask = (bus_wr && kind == ACC_CLEAR) ? bus_wdata[NUM_SRC-1:0] : '0;

    always_comb begin
        bus_rdata = '0;
        case (kind)
            ACC_CTRL: begin
                for (int unsigned w = 0; w < NUM_WORDS; w++) begin
                    if (word == WORD_W'(w)) begin
                        bus_rdata = cfg_q[w*FIELDS_PER_WORD +: FIELDS_PER_WORD];
                    end
                end
            end
            ACC_STATUS: bus_rdata = DATA_W'(pend_q);
            default:    bus_rdata = '0;
        endcase
    end

    irq_cfg_regs #(
        .NUM_SRC    (NUM_SRC),
        .WORD_IDX_W (WORD_W)
    ) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr && kind == ACC_CTRL),
        .wr_word (word),
        .wr_data (bus_wdata),
        .cfg     (cfg_q)
    );

    irq_pending #(
        .NUM_SRC   (NUM_SRC),
        .LEVEL_SRC (LEVEL_SRC)
    ) pend_i (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .clr_mask (clr_mask),
        .pend     (pend_q)
    );

    irq_route #(
        .NUM_SRC   (NUM_SRC),
        .NUM_LINES (NUM_LINES)
    ) route_i (
        .clk    (clk),
        .rst    (rst),
        .pend   (pend_q),
        .cfg    (cfg_q),
        .line_q (irq_line)
    );
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int unsigned         NUM_SRC   = 32,
    parameter int unsigned         NUM_LINES = 7,
    parameter logic [NUM_SRC-1:0]  LEVEL_SRC = '0
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_SRC-1:0]      src_in,
    input logic [NUM_SRC-1:0]      clr_mask,
    input logic [NUM_SRC-1:0]      pend,
    input src_cfg_t [NUM_SRC-1:0]  cfg,
    input logic [NUM_LINES-1:0]    irq_line
);
    logic [NUM_SRC-1:0] src_seen;
    logic [NUM_SRC-1:0] en_mask;
    logic [NUM_SRC-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) src_seen <= '0;
        else     src_seen <= src_in;
    end

    always_comb begin
        for (int unsigned s = 0; s < NUM_SRC; s++) en_mask[s] = cfg[s].enable;
    end

    assign rise = src_in & ~src_seen & ~LEVEL_SRC;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_line == '0 && pend == '0));

    if (NUM_LINES > UNUSED_LINE) begin : g_idle
        // R3
        idle_line_chk: assert property (@(posedge clk) disable iff (rst)
            !irq_line[UNUSED_LINE]);
    end

    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en_mask == '0) |=> (irq_line == '0));

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (((($past(pend) & ~$past(clr_mask)) & ~LEVEL_SRC) & ~pend) == '0));

    // R7
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));

    // R8
    level_track_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (((pend ^ $past(src_in)) & LEVEL_SRC) == '0));
endmodule

bind irq_router irq_router_chk #(
    .NUM_SRC   (NUM_SRC),
    .NUM_LINES (NUM_LINES),
    .LEVEL_SRC (LEVEL_SRC)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .src_in   (src_in),
    .clr_mask (clr_mask),
    .pend     (pend_q),
    .cfg      (cfg_q),
    .irq_line (irq_line)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] TB_LEVEL   = 32'hFF00_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic [6:0]  irq_line;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router #(
        .NUM_SRC   (32),
        .NUM_LINES (7),
        .ADDR_W    (5),
        .LEVEL_SRC (TB_LEVEL)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_line  (irq_line)
    );

    // Behavioural reference model, advanced on each rising edge.
    logic [31:0] m_ctrl [4];
    logic [31:0] m_pend, m_prev, m_clr, m_np;
    logic [6:0]  m_line, m_nl;
    logic [3:0]  m_nib;

    always @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < 4; w++) m_ctrl[w] = '0;
            m_pend = '0;
            m_prev = '0;
            m_line = '0;
        end else begin
            m_nl = '0;
            for (int s = 0; s < 32; s++) begin
                m_nib = m_ctrl[s/8][(s%8)*4 +: 4];
                if (m_pend[s] && m_nib[3] && m_nib[2:0] != 3'd5 && m_nib[2:0] != 3'd7)
                    m_nl[m_nib[2:0]] = 1'b1;
            end
            m_clr = (bus_wr && bus_addr[4:2] == 3'd4) ? bus_wdata : 32'h0;
            for (int s = 0; s < 32; s++) begin
                if (TB_LEVEL[s]) m_np[s] = src_in[s];
                else m_np[s] = (src_in[s] && !m_prev[s]) || (m_pend[s] && !m_clr[s]);
            end
            if (bus_wr && bus_addr[4:2] < 3'd4) m_ctrl[bus_addr[4:2]] = bus_wdata;
            m_pend = m_np;
            m_prev = src_in;
            m_line = m_nl;
        end
    end

    function automatic logic [31:0] model_read(logic [4:0] a);
        if (a[4:2] < 3'd4)  return m_ctrl[a[4:2]];
        if (a[4:2] == 3'd5) return m_pend;
        return 32'h0;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison a quarter period after the falling edge.
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (!rst && !finished) begin
            chk("R3 R4 R10 model lines", {25'h0, irq_line}, {25'h0, m_line});
            chk("R2 R9 R11 model read", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        // R1: reset state
        chk("R1 lines after reset", {25'h0, irq_line}, 32'h0);
        for (int w = 0; w < 4; w++) rd_chk("R1 control word zero", 5'(w*4), 32'h0);
        rd_chk("R1 pending zero", 5'h14, 32'h0);

        // R2: word storage and field placement
        wr(5'h00, 32'h1234_5678);
        rd_chk("R2 word0 readback", 5'h00, 32'h1234_5678);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0000_A000);   // source 11: enable, selector 2
        rd_chk("R2 word1 readback", 5'h04, 32'h0000_A000);

        // R5 / R10: edge latch and registered line
        src_in[11] = 1'b1;
        cyc(1);
        rd_chk("R9 pending after edge", 5'h14, 32'h0000_0800);
        chk("R10 line lags pending", {25'h0, irq_line}, 32'h0);
        cyc(1);
        chk("R5 line 2 from source 11", {25'h0, irq_line}, 32'h4);
        src_in[11] = 1'b0;
        cyc(2);
        chk("R5 sticky after input falls", {25'h0, irq_line}, 32'h4);

        // R6: write-one-to-clear
        wr(5'h10, 32'hFFFF_F7FF);
        cyc(1);
        chk("R6 zero bit keeps line", {25'h0, irq_line}, 32'h4);
        rd_chk("R6 zero bit keeps pending", 5'h14, 32'h0000_0800);
        wr(5'h10, 32'h0000_0800);
        rd_chk("R6 one bit clears pending", 5'h14, 32'h0);
        chk("R10 line lags clear", {25'h0, irq_line}, 32'h4);
        cyc(1);
        chk("R6 line drops", {25'h0, irq_line}, 32'h0);

        // R7: edge beats clear in the same cycle
        src_in[11] = 1'b1;
        wr(5'h10, 32'h0000_0800);
        rd_chk("R7 edge wins over clear", 5'h14, 32'h0000_0800);
        wr(5'h10, 32'h0000_0800);
        rd_chk("R6 clear with input held", 5'h14, 32'h0);
        src_in[11] = 1'b0;
        cyc(2);

        // R3: selector decode
        wr(5'h04, 32'h0000_D000);   // enable, selector 5
        src_in[11] = 1'b1;
        cyc(2);
        chk("R3 selector 5 drives nothing", {25'h0, irq_line}, 32'h0);
        rd_chk("R9 pending with sel 5", 5'h14, 32'h0000_0800);
        wr(5'h04, 32'h0000_C000);   // selector 4
        chk("R10 routing change lags", {25'h0, irq_line}, 32'h0);
        cyc(1);
        chk("R3 selector 4", {25'h0, irq_line}, 32'h10);
        wr(5'h04, 32'h0000_F000);   // selector 7
        cyc(1);
        chk("R3 selector 7 drives nothing", {25'h0, irq_line}, 32'h0);
        wr(5'h04, 32'h0000_E000);   // selector 6
        cyc(1);
        chk("R3 selector 6", {25'h0, irq_line}, 32'h40);

        // R4 / R9: disable masks line but not status
        wr(5'h04, 32'h0000_6000);
        cyc(1);
        chk("R4 disabled source silent", {25'h0, irq_line}, 32'h0);
        rd_chk("R9 status ignores enable", 5'h14, 32'h0000_0800);

        // R8: level source 26 (word 3, bits 11:8)
        wr(5'h0C, 32'h0000_0900);   // enable, selector 1
        src_in[26] = 1'b1;
        cyc(2);
        chk("R8 level line 1", {25'h0, irq_line}, 32'h2);
        wr(5'h10, 32'h0400_0000);
        rd_chk("R8 clear ignored while held", 5'h14, 32'h0400_0800);
        cyc(2);
        chk("R8 line held", {25'h0, irq_line}, 32'h2);
        src_in[26] = 1'b0;
        cyc(1);
        rd_chk("R8 pending follows input", 5'h14, 32'h0000_0800);
        cyc(1);
        chk("R8 line drops", {25'h0, irq_line}, 32'h0);

        // R11: writes to status or unmapped words are ignored
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd_chk("R11 status unchanged", 5'h14, 32'h0000_0800);
        rd_chk("R11 word1 unchanged", 5'h04, 32'h0000_6000);
        rd_chk("R11 word3 unchanged", 5'h0C, 32'h0000_0900);
        rd_chk("R11 word0 unchanged", 5'h00, 32'h0);
        rd_chk("R11 word2 unchanged", 5'h08, 32'h0);
        rd_chk("R11 unmapped reads zero", 5'h18, 32'h0);
        rd_chk("R11 clear reads zero", 5'h10, 32'h0);
        chk("R11 lines unchanged", {25'h0, irq_line}, 32'h0);
        src_in[11] = 1'b0;

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            src_in    = src_in ^ ($urandom & $urandom & $urandom);
            bus_wr    = ($urandom % 4) == 0;
            bus_addr  = 5'($urandom);
            bus_wdata = $urandom;
        end
        @(negedge clk);
        bus_wr = 1'b0;
        cyc(3);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule